// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as separate fields: a sign, a class code, an unbiased signed exponent, a mantissa whose leading one sits at the top bit with `FRAC_W` fraction bits and two extra low bits below it, and a separate sticky bit. The block shifts the mantissa down to the integer point, drops the fraction, checks the range and forms the two's complement for negative values. It always rounds toward zero, whatever rounding mode the surrounding unit is using.

Two status flags go with each result: inexact and operand error. Each result carries only its own flags. The caller ORs them into its own accumulated status register, and this block never clears that register. When the value does not fit, the block replaces inexact with operand error and returns the saturation pattern for the operand's sign. The range is asymmetric: -2^31 fits and +2^31 does not. A valid/ready handshake on each side moves one conversion at a time through a single output register.

The numeric value of a number-class operand is `mant * 2^(exp - FRAC_W - 2)`. The design requires `FRAC_W + 2 >= INT_W`.

Top module: `fp_int_cvt`

## Requirements
- R1: Class code 0 (zero) gives result 0 with inexact and operand error both low, whatever the sign, exponent, mantissa and sticky inputs are.
- R2: A positive number-class operand in range gives the magnitude of its value with the fraction dropped (truncation toward zero).
- R3: A negative number-class operand in range gives the two's complement of its truncated magnitude. A truncated magnitude of exactly 0x80000000 with sign 1 is in range and gives 0x80000000.
- R4: For an in-range number-class operand, inexact is 1 exactly when a discarded mantissa bit (including the two low extra bits) is 1 or the sticky input is 1.
- R5: A number-class operand with a negative exponent, down to the most negative exponent, gives 0. Inexact is 1 if any mantissa bit or the sticky bit is 1. No underflow is signalled.
- R6: A number-class operand with exponent 32 or more overflows.
- R7: A number-class operand overflows when its truncated magnitude is at least 0x80000000 plus the sign bit.
- R8: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 all overflow.
- R9: On overflow, operand error is 1, inexact is 0, and the result is 0x7FFFFFFF for sign 0 or 0x80000000 for sign 1.
- R10: An operand accepted on a clock edge (in_valid_i and in_ready_o both high) shows up on the outputs with out_valid_o high right after that edge. While out_ready_i is low the output stays valid and unchanged. in_ready_o is high when the output register is empty or being drained.
- R11: After reset, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand present |
| in_ready_o | output | 1 | Block can take an operand |
| sign_i | input | 1 | Operand sign, 1 = negative |
| class_i | input | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| exp_i | input | EXP_W (16) | Unbiased exponent, two's complement |
| mant_i | input | FRAC_W+3 (55) | Leading one, fraction, two extra low bits |
| sticky_i | input | 1 | OR of bits already lost below the mantissa |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | INT_W (32) | Two's-complement integer |
| inexact_o | output | 1 | Nonzero bits were discarded |
| operr_o | output | 1 | Value out of range or not a number |

## Verification
A wrong shift amount in the alignment path shows up on the very next valid result as a value off by a power of two. It can also show up as an inexact flag that disagrees with the discarded bits, most visibly near exponents 0, 31 and 32. A bad range threshold only appears at the two boundary magnitudes 0x7FFFFFFF/0x80000000, and only for one sign, so both signs are driven at exactly those values. A fault in the output register appears as a changed result during a stall, or as a result dropped or repeated when the consumer holds off. The scoreboard sees either case at the next handshake.

// File: rtl/fp_int_pkg.sv
package fp_int_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } op_class_e;
endpackage

// File: rtl/fp_int_align.sv
// Shifts the mantissa down to the integer point and collects discarded bits.
module fp_int_align #(
  parameter int EXP_W  = 16,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0]    exp_i,
  input  logic [FRAC_W+2:0]   mant_i,
  output logic                big_o,
  output logic [INT_W-1:0]    mag_o,
  output logic                lost_o
);
  localparam int MANT_W = FRAC_W + 3;
  localparam int POINT  = FRAC_W + 2;
  localparam int SH_W   = $clog2(MANT_W + 1);
  localparam int XW     = EXP_W + 2;

  logic signed [XW-1:0] exp_x;
  logic signed [XW-1:0] sh_full;
  logic [SH_W-1:0]      sh;
  logic [MANT_W-1:0]    keep_mask;

  assign exp_x   = XW'($signed(exp_i));
  assign sh_full = XW'(POINT) - exp_x;
  assign big_o   = exp_x >= XW'(INT_W);

  // clamp: everything shifted out below the point, nothing shifted when big
  always_comb begin
    if (sh_full >= XW'(MANT_W))  sh = SH_W'(MANT_W);
    else if (sh_full < 0)        sh = '0;
    else                         sh = sh_full[SH_W-1:0];
  end

  assign keep_mask = {MANT_W{1'b1}} << sh;
  assign lost_o    = |(mant_i & ~keep_mask);
  assign mag_o     = INT_W'(mant_i >> sh);
endmodule

// File: rtl/fp_int_range.sv
// Range check, saturation, negation and flag selection.
module fp_int_range
  import fp_int_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  op_class_e        cls_i,
  input  logic             big_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             sticky_i,
  output logic [INT_W-1:0] res_o,
  output logic             inexact_o,
  output logic             operr_o
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W:0] limit;
  logic           ovf_mag, is_zero, is_num, ovf;

  // negative side admits one extra magnitude
  assign limit   = {1'b0, NEG_SAT} + {{INT_W{1'b0}}, sign_i};
  assign ovf_mag = {1'b0, mag_i} >= limit;
  assign is_zero = cls_i == CLS_ZERO;
  assign is_num  = cls_i == CLS_NUM;
  assign ovf     = !is_zero && (!is_num || big_i || ovf_mag);

  always_comb begin
    if (is_zero)      res_o = '0;
    else if (ovf)     res_o = sign_i ? NEG_SAT : POS_SAT;
    else if (sign_i)  res_o = ~mag_i + INT_W'(1);
    else              res_o = mag_i;
  end

  assign inexact_o = is_num && !ovf && (lost_i || sticky_i);
  assign operr_o   = ovf;
endmodule

// File: rtl/fp_int_cvt.sv
module fp_int_cvt
  import fp_int_pkg::*;
#(
  parameter int EXP_W  = 16,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              sign_i,
  input  logic [2:0]        class_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W+2:0] mant_i,
  input  logic              sticky_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [INT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              operr_o
);
  op_class_e        cls;
  logic             big, lost, accept;
  logic [INT_W-1:0] mag, res_d;
  logic             inexact_d, operr_d;
  logic             out_valid_q, inexact_q, operr_q;
  logic [INT_W-1:0] result_q;

  assign cls = op_class_e'(class_i);

  fp_int_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .exp_i  (exp_i),
    .mant_i (mant_i),
    .big_o  (big),
    .mag_o  (mag),
    .lost_o (lost)
  );

  fp_int_range #(.INT_W(INT_W)) u_range (
    .sign_i    (sign_i),
    .cls_i     (cls),
    .big_i     (big),
    .mag_i     (mag),
    .lost_i    (lost),
    .sticky_i  (sticky_i),
    .res_o     (res_d),
    .inexact_o (inexact_d),
    .operr_o   (operr_d)
  );

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      result_q    <= '0;
      inexact_q   <= 1'b0;
      operr_q     <= 1'b0;
    end else if (accept) begin
      out_valid_q <= 1'b1;
      result_q    <= res_d;
      inexact_q   <= inexact_d;
      operr_q     <= operr_d;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign result_o    = result_q;
  assign inexact_o   = inexact_q;
  assign operr_o     = operr_q;

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o)
      && $stable(inexact_o) && $stable(operr_o));

  p_zero_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && class_i == 3'd0 |=> result_o == '0 && !inexact_o && !operr_o);

  p_big_exp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && class_i == 3'd1 && $signed(exp_i) >= INT_W |=> operr_o);

  p_non_number_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && class_i >= 3'd2 |=> operr_o);

  p_sat_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && operr_o |-> !inexact_o
      && (result_o == {1'b0, {(INT_W-1){1'b1}}} || result_o == {1'b1, {(INT_W-1){1'b0}}}));
endmodule

// File: tb/fp_int_cvt_bench.sv
module fp_int_cvt_bench;
  localparam int EXP_W = 16;
  localparam int FRAC_W = 52;
  localparam int INT_W = 32;
  localparam int MW = FRAC_W + 3;
  localparam logic [MW-1:0] ONE = {1'b1, {(MW-1){1'b0}}};

  logic clk_i = 0, rst_ni = 0;
  logic in_valid_i = 0, in_ready_o;
  logic sign_i = 0, sticky_i = 0;
  logic [2:0] class_i = 0;
  logic [EXP_W-1:0] exp_i = 0;
  logic [MW-1:0] mant_i = 0;
  logic out_valid_o, out_ready_i = 1;
  logic [INT_W-1:0] result_o;
  logic inexact_o, operr_o;

  int n_chk = 0, n_bad = 0;
  bit stall_en = 0, done = 0;
  logic [33:0] exp_q[$];
  string tag_q[$];

  always #5 clk_i = ~clk_i;

  fp_int_cvt #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_fp_int_cvt (.*);

  // expected {operr, inexact, result}
  function automatic logic [33:0] model(input logic sg, input logic [2:0] cl,
      input logic signed [15:0] ex, input logic [MW-1:0] mt, input logic st);
    logic [127:0] full, mag;
    logic lost;
    int sh;
    if (cl == 3'd0) return 34'd0;
    if (cl != 3'd1 || ex >= 16'sd32)
      return {2'b10, sg ? 32'h8000_0000 : 32'h7FFF_FFFF};
    sh = (FRAC_W + 2) - int'(ex);
    full = 128'(mt);
    if (sh >= 120) begin mag = '0; lost = (mt != 0); end
    else begin mag = full >> sh; lost = ((mag << sh) != full); end
    if (mag >= 128'h8000_0000 + 128'(sg))
      return {2'b10, sg ? 32'h8000_0000 : 32'h7FFF_FFFF};
    return {1'b0, lost | st, sg ? (~mag[31:0] + 32'd1) : mag[31:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input string tag, input logic sg, input logic [2:0] cl,
      input int ex, input logic [MW-1:0] mt, input logic st);
    @(negedge clk_i);
    sign_i = sg; class_i = cl; exp_i = EXP_W'(ex); mant_i = mt; sticky_i = st;
    in_valid_i = 1;
    #1;
    while (!in_ready_o) begin @(negedge clk_i); #1; end
    exp_q.push_back(model(sg, cl, EXP_W'(ex), mt, st));
    tag_q.push_back(tag);
    @(posedge clk_i); #1;
    in_valid_i = 0;
    check(out_valid_o === 1'b1, "R10 latency", 34'(out_valid_o), 34'd1);
  endtask

  // consumer back-pressure
  always @(negedge clk_i) out_ready_i <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  // monitor
  initial begin
    forever begin
      @(negedge clk_i); #2;
      if (rst_ni && out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) check(0, "R10 spurious", {operr_o, inexact_o, result_o}, 34'd0);
        else begin
          logic [33:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check({operr_o, inexact_o, result_o} === e, t, {operr_o, inexact_o, result_o}, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R11 reset", {32'd0, out_valid_o, in_ready_o}, 34'd1);
    rst_ni = 1;
    send("R1 zero with sticky", 1, 3'd0, 40, ONE | 55'd7, 1);
    send("R2 one", 0, 3'd1, 0, ONE, 0);
    send("R2/R4 one and a half", 0, 3'd1, 0, ONE | (ONE >> 1), 0);
    send("R4 sticky only", 0, 3'd1, 0, ONE, 1);
    send("R4 low extra bit", 0, 3'd1, 5, ONE | 55'd1, 0);
    send("R2 two pow 30", 0, 3'd1, 30, ONE, 0);
    send("R2 max positive", 0, 3'd1, 30, {MW{1'b1}}, 0);
    send("R7 positive 2^31", 0, 3'd1, 31, ONE, 0);
    send("R3 negative 2^31 exact", 1, 3'd1, 31, ONE, 0);
    send("R3/R4 negative 2^31 sticky", 1, 3'd1, 31, ONE, 1);
    send("R7 negative 2^31+1", 1, 3'd1, 31, ONE | (ONE >> 31), 0);
    send("R3 negative 7.25", 1, 3'd1, 2, ONE | (55'hD << 50), 0);
    send("R5 half", 0, 3'd1, -1, ONE, 0);
    send("R5 negative tiny", 1, 3'd1, -100, ONE, 0);
    send("R5 most negative exp", 0, 3'd1, -32768, ONE, 0);
    send("R6 exp 32", 0, 3'd1, 32, ONE, 0);
    send("R6 exp max negative sign", 1, 3'd1, 32767, ONE, 1);
    send("R8 infinity", 0, 3'd2, 0, 0, 0);
    send("R8 quiet nan", 1, 3'd3, 0, ONE, 0);
    send("R8 signalling nan", 0, 3'd4, 0, ONE, 1);
    send("R8 unused code", 1, 3'd7, 0, 0, 0);
    send("R9 saturate negative", 1, 3'd2, 0, 0, 1);
    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      logic [MW-1:0] m;
      int e;
      m = ONE | {$urandom, $urandom};
      e = int'($urandom % 44) - 8;
      send("R2/R3/R4/R7 random", 1'($urandom), ($urandom % 8 == 0) ? 3'($urandom) : 3'd1, e, m, 1'($urandom));
    end
    stall_en = 0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk_i);
    check(exp_q.size() == 0, "R10 drained", 34'(exp_q.size()), 34'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule